// File: doc/BRIEF.md
# Audio Serial Interface Register Bank

This block is the software-visible register file of an audio serial interface controller. A processor reaches it through a simple word-indexed read/write port. The bank holds the interface control and mode words, FIFO and prescaler settings, data words, the DMA control word, DMA start addresses, the DMA buffer size, a DMA transfer counter and four buffer-level watch addresses.

Writes are filtered per register. The control and DMA control words only accept their writable fields. A falling software-reset bit returns the whole bank to its reset image. Interrupt flags are set by events from the datapath and cleared by writing ones. The serial shifter, the FIFOs and the memory fetch engine sit outside the bank. They deliver FIFO status bits, level-hit events, a DMA event and transfer-count advances. In return they receive a DMA enable level, a pulse when that enable changes, and a single interrupt line.

Top module: `audio_ctl_regbank`

## Requirements
- R1: After reset every word reads 0, except the DMA size word (index 10), which reads 0x7FFF0000. The outputs `irq_o`, `dma_en_o`, `dma_en_chg_o`, `rsp_err_o` and `rsp_rdata_o` are all 0.
- R2: A write to the control word (index 0) changes only the bits set in 0x8295007F; the other bits keep their old value. On a read of this word, bits 15:7 show `fifo_stat_i[8:0]`.
- R3: A write to the control word with bit 31 at 0, while the stored bit 31 is 1, is a software reset. Every other word returns to its R1 value, all interrupt flags clear, and `irq_o` is low after that edge. The control word takes the written value masked by 0x8295007F. If DMA enable was 1, `dma_en_chg_o` pulses.
- R4: A write to the DMA control word (index 8) changes only the stored bits in 0xFF0000FB. On a read, bits 23:20 show the interrupt flags of levels 3..0 and bit 2 shows the DMA interrupt flag. Bits 19:16 and 15:8 read 0.
- R5: In a cycle where DMA control bit 24+i (level enable) is set, a pulse on `lvl_evt_i[i]` sets level flag i. In a cycle where bit 0 (DMA enable) is set, a pulse on `dma_evt_i` sets the DMA flag. `irq_o` is a register equal to the OR of all flags after each edge.
- R6: Writing 1 to DMA control bit 16+i clears level flag i, and writing 1 to bit 1 clears the DMA flag. An event that arrives in the same cycle as its clear still sets the flag.
- R7: `dma_en_o` follows stored DMA control bit 0. A write that takes that bit from 1 to 0 clears all flags and drops `irq_o`, and the clear overrides events in the same cycle. Any write that changes bit 0 pulses `dma_en_chg_o` for one cycle after the edge.
- R8: The transfer count word (index 11) is read-only. A write to it leaves the count unchanged and pulses `rsp_err_o`.
- R9: A size-word write whose bits 31:16 are 0 is rejected: the size word is unchanged and `rsp_err_o` pulses. Any other size write stores the value. If its bits 31:16 are less than or equal to the current count, the count becomes 0.
- R10: A pulse on `cnt_adv_i` sets the count (bits 23:0 of index 11) to (count + `cnt_step_i`) modulo the size field. The advance is ignored in a cycle that writes the size word or performs a software reset.
- R11: An access with index 17 or above pulses `rsp_err_o`, changes no state, and a read of such an index returns 0.
- R12: A read returns the word as stored before that edge on `rsp_rdata_o`, one cycle after the request. `rsp_rdata_o` holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Word index |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Registered read data |
| rsp_err_o | output | 1 | One-cycle error pulse for rejected or out-of-window access |
| fifo_stat_i | input | 9 | Live FIFO status bits shown in control bits 15:7 |
| lvl_evt_i | input | 4 | Buffer-level hit events, one per level |
| dma_evt_i | input | 1 | DMA interrupt event |
| cnt_adv_i | input | 1 | Transfer count advance strobe |
| cnt_step_i | input | 16 | Words to advance |
| dma_en_o | output | 1 | DMA enable level to the datapath |
| dma_en_chg_o | output | 1 | One-cycle pulse when DMA enable changes |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The counter assertion assumes that an advance step never exceeds the size field, so the count always stays below the size. The datapath is expected to honour this, and the stimulus draws every step from zero up to the size currently held in the reference model. The flag assertions assume level and DMA events are single-cycle pulses that may coincide with clear writes. The stimulus deliberately lines events up with clears, with enable drops and with software resets. Random writes cover the whole index range, including the rejected count index, size values with a zero field and indices past the window.

// File: rtl/audio_rb_pkg.sv
// Package: shared sizes, word indices, write masks and reset image for the
// audio interface register bank. Assumes 32-bit words and word indexing.
package audio_rb_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 17;
    localparam int ADDR_W     = $clog2(NUM_WORDS + 15);
    localparam int NUM_LVL    = 4;
    localparam int SIZE_W     = 16;
    localparam int SIZE_LSB   = 16;
    localparam int CNT_W      = 24;
    localparam int STAT_W     = 9;
    localparam int STAT_LSB   = 7;

    localparam int IDX_CTL    = 0;
    localparam int IDX_DMACTL = 8;
    localparam int IDX_SIZE   = 10;
    localparam int IDX_CNT    = 11;

    localparam logic [WORD_W-1:0] CTL_WMASK = 32'h8295_007F;
    localparam logic [WORD_W-1:0] DMA_WMASK = 32'hFF00_00FB;
    localparam logic [WORD_W-1:0] SIZE_RST  = 32'h7FFF_0000;

    localparam int CTL_SRST_BIT  = 31;
    localparam int LVL_EN_LSB    = 24;
    localparam int LVL_FLAG_LSB  = 20;
    localparam int LVL_CLR_LSB   = 16;
    localparam int DMA_EN_BIT    = 0;
    localparam int DMA_CLR_BIT   = 1;
    localparam int DMA_FLAG_BIT  = 2;

    // Decoded access, produced by the word decoder.
    typedef struct packed {
        logic                 in_win;
        logic                 rd_en;
        logic                 err;
        logic [NUM_WORDS-1:0] wr_sel;
    } acc_dec_t;
endpackage

// File: rtl/audio_rb_decode.sv
// Word decoder: turns a request into per-word write selects, a read enable
// and an error flag. Assumes one access per cycle; purely combinational.
module audio_rb_decode
    import audio_rb_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] size_field,
    output acc_dec_t          dec
);
    logic in_win;
    logic wr_any;
    logic size_zero;

    // Window check and write qualification.
    always_comb begin
        in_win    = (req_addr < ADDR_W'(NUM_WORDS));
        wr_any    = req_valid && req_write && in_win;
        size_zero = (size_field == '0);
    end

    // One select per word; the count word is never writable and a size write
    // with an empty size field is dropped.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_sel
        if (i == IDX_CNT) begin : g_ro
            assign dec.wr_sel[i] = 1'b0;
        end else if (i == IDX_SIZE) begin : g_size
            assign dec.wr_sel[i] = wr_any && (req_addr == ADDR_W'(i)) && !size_zero;
        end else begin : g_rw
            assign dec.wr_sel[i] = wr_any && (req_addr == ADDR_W'(i));
        end
    end

    // Error and read strobes.
    always_comb begin
        dec.in_win = in_win;
        dec.rd_en  = req_valid && !req_write;
        dec.err    = req_valid && (!in_win ||
                     (req_write && req_addr == ADDR_W'(IDX_CNT)) ||
                     (req_write && req_addr == ADDR_W'(IDX_SIZE) && size_zero));
    end
endmodule

// File: rtl/audio_rb_irq.sv
// Interrupt flag unit: level and DMA flags with set-by-event, write-one-to-
// clear and flush; drives a registered IRQ. Assumes events are pulses.
module audio_rb_irq #(
    parameter int N_LVL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [N_LVL-1:0] lvl_en,
    input  logic [N_LVL-1:0] lvl_evt,
    input  logic [N_LVL-1:0] lvl_clr,
    input  logic             dma_en,
    input  logic             dma_evt,
    input  logic             dma_clr,
    output logic [N_LVL-1:0] lvl_flag,
    output logic             dma_flag,
    output logic             irq_o
);
    logic [N_LVL-1:0] lvl_set;
    logic [N_LVL-1:0] lvl_nxt;
    logic             dma_set;
    logic             dma_nxt;

    // Next flag values: flush wins, then set beats clear.
    always_comb begin
        lvl_set = lvl_evt & lvl_en;
        dma_set = dma_evt && dma_en;
        if (flush) begin
            lvl_nxt = '0;
            dma_nxt = 1'b0;
        end else begin
            lvl_nxt = (lvl_flag & ~lvl_clr) | lvl_set;
            dma_nxt = (dma_flag && !dma_clr) || dma_set;
        end
    end

    // Flag and IRQ registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_flag <= '0;
            dma_flag <= 1'b0;
            irq_o    <= 1'b0;
        end else begin
            lvl_flag <= lvl_nxt;
            dma_flag <= dma_nxt;
            irq_o    <= (|lvl_nxt) || dma_nxt;
        end
    end

    for (genvar i = 0; i < N_LVL; i++) begin : g_chk
        p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_clr[i] && !(lvl_evt[i] && lvl_en[i])) |=> !lvl_flag[i]);
    end

    p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (((|(lvl_evt & lvl_en)) || (dma_evt && dma_en)) && !flush) |=> irq_o);

    p_flush_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!irq_o && lvl_flag == '0 && !dma_flag));
endmodule

// File: rtl/audio_rb_count.sv
// Transfer counter: holds the DMA size word and the read-only transfer
// count. Assumes an advance step never exceeds the size field.
module audio_rb_count #(
    parameter int W      = 32,
    parameter int S_W    = 16,
    parameter int S_LSB  = 16,
    parameter int C_W    = 24,
    parameter logic [W-1:0] S_RST = 32'h7FFF_0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           soft_rst,
    input  logic           size_we,
    input  logic [W-1:0]   size_wdata,
    input  logic           adv,
    input  logic [S_W-1:0] step,
    output logic [W-1:0]   size_q,
    output logic [C_W-1:0] cnt_q
);
    localparam int SUM_W = C_W + 1;

    logic [S_W-1:0]   size_f;
    logic [S_W-1:0]   new_f;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrap;

    // Field extraction and wrapped sum.
    always_comb begin
        size_f = size_q[S_LSB +: S_W];
        new_f  = size_wdata[S_LSB +: S_W];
        sum    = SUM_W'(cnt_q) + SUM_W'(step);
        wrap   = (sum >= SUM_W'(size_f)) ? (sum - SUM_W'(size_f)) : sum;
    end

    // Size and count registers: reset, size write with reconcile, advance.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            size_q <= S_RST;
            cnt_q  <= '0;
        end else if (size_we) begin
            size_q <= size_wdata;
            if (C_W'(new_f) <= cnt_q) begin
                cnt_q <= '0;
            end
        end else if (adv) begin
            cnt_q <= wrap[C_W-1:0];
        end
    end

    p_cnt_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < C_W'(size_q[S_LSB +: S_W]));

    p_size_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        size_q[S_LSB +: S_W] != '0);
endmodule

// File: rtl/audio_ctl_regbank.sv
// Top: audio interface register bank. Holds control, DMA control and plain
// words, instantiates decoder, flag unit and counter, and forms read data.
// Assumes one access per cycle and single-cycle datapath events.
module audio_ctl_regbank
    import audio_rb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [WORD_W-1:0]   req_wdata_i,
    output logic [WORD_W-1:0]   rsp_rdata_o,
    output logic                rsp_err_o,
    input  logic [STAT_W-1:0]   fifo_stat_i,
    input  logic [NUM_LVL-1:0]  lvl_evt_i,
    input  logic                dma_evt_i,
    input  logic                cnt_adv_i,
    input  logic [SIZE_W-1:0]   cnt_step_i,
    output logic                dma_en_o,
    output logic                dma_en_chg_o,
    output logic                irq_o
);
    acc_dec_t            dec;
    logic [WORD_W-1:0]   ctl_q;
    logic [WORD_W-1:0]   dma_q;
    logic [WORD_W-1:0]   size_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [NUM_LVL-1:0]  lvl_flag;
    logic                dma_flag;
    logic                soft_rst;
    logic                dma_off;
    logic                dma_wr;
    logic                size_touch;
    logic                adv_eff;
    logic [NUM_LVL-1:0]  lvl_clr;
    logic [WORD_W-1:0]   rd_words [NUM_WORDS];

    audio_rb_decode u_dec (
        .req_valid  (req_valid_i),
        .req_write  (req_write_i),
        .req_addr   (req_addr_i),
        .size_field (req_wdata_i[SIZE_LSB +: SIZE_W]),
        .dec        (dec)
    );

    // Control strobes derived from the decoded access.
    always_comb begin
        soft_rst   = dec.wr_sel[IDX_CTL] && ctl_q[CTL_SRST_BIT] && !req_wdata_i[CTL_SRST_BIT];
        dma_wr     = dec.wr_sel[IDX_DMACTL];
        dma_off    = dma_wr && dma_q[DMA_EN_BIT] && !req_wdata_i[DMA_EN_BIT];
        lvl_clr    = dma_wr ? req_wdata_i[LVL_CLR_LSB +: NUM_LVL] : '0;
        size_touch = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(IDX_SIZE));
        adv_eff    = cnt_adv_i && !size_touch && !soft_rst;
    end

    // Control word: masked write; software reset keeps only the new value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (soft_rst) begin
            ctl_q <= req_wdata_i & CTL_WMASK;
        end else if (dec.wr_sel[IDX_CTL]) begin
            ctl_q <= (ctl_q & ~CTL_WMASK) | (req_wdata_i & CTL_WMASK);
        end
    end

    // DMA control word: masked write of enables, clears and options.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            dma_q <= '0;
        end else if (dma_wr) begin
            dma_q <= (dma_q & ~DMA_WMASK) | (req_wdata_i & DMA_WMASK);
        end
    end

    // Enable-change pulse to the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en_chg_o <= 1'b0;
        end else begin
            dma_en_chg_o <= (dma_wr && (dma_q[DMA_EN_BIT] != req_wdata_i[DMA_EN_BIT])) ||
                            (soft_rst && dma_q[DMA_EN_BIT]);
        end
    end

    assign dma_en_o = dma_q[DMA_EN_BIT];

    audio_rb_irq #(.N_LVL(NUM_LVL)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (soft_rst || dma_off),
        .lvl_en   (dma_q[LVL_EN_LSB +: NUM_LVL]),
        .lvl_evt  (lvl_evt_i),
        .lvl_clr  (lvl_clr),
        .dma_en   (dma_q[DMA_EN_BIT]),
        .dma_evt  (dma_evt_i),
        .dma_clr  (dma_wr && req_wdata_i[DMA_CLR_BIT]),
        .lvl_flag (lvl_flag),
        .dma_flag (dma_flag),
        .irq_o    (irq_o)
    );

    audio_rb_count #(
        .W     (WORD_W),
        .S_W   (SIZE_W),
        .S_LSB (SIZE_LSB),
        .C_W   (CNT_W),
        .S_RST (SIZE_RST)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .size_we    (dec.wr_sel[IDX_SIZE]),
        .size_wdata (req_wdata_i),
        .adv        (adv_eff),
        .step       (cnt_step_i),
        .size_q     (size_q),
        .cnt_q      (cnt_q)
    );

    // Per-word storage and read view; special words are composed here.
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        if (i == IDX_CTL) begin : g_ctl
            assign rd_words[i] = ctl_q | (WORD_W'(fifo_stat_i) << STAT_LSB);
        end else if (i == IDX_DMACTL) begin : g_dma
            assign rd_words[i] = dma_q
                               | (WORD_W'(lvl_flag) << LVL_FLAG_LSB)
                               | (WORD_W'(dma_flag) << DMA_FLAG_BIT);
        end else if (i == IDX_SIZE) begin : g_size
            assign rd_words[i] = size_q;
        end else if (i == IDX_CNT) begin : g_cnt
            assign rd_words[i] = WORD_W'(cnt_q);
        end else begin : g_plain
            logic [WORD_W-1:0] word_q;
            // Plain word: full-width store, cleared by either reset.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) begin
                    word_q <= '0;
                end else if (dec.wr_sel[i]) begin
                    word_q <= req_wdata_i;
                end
            end
            assign rd_words[i] = word_q;
        end
    end

    // Registered read data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata_o <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_err_o <= dec.err;
            if (dec.rd_en) begin
                rsp_rdata_o <= dec.in_win ? rd_words[req_addr_i] : '0;
            end
        end
    end

    p_oow_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && (req_addr_i >= ADDR_W'(NUM_WORDS))) |=> rsp_err_o);

    p_cnt_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_addr_i == ADDR_W'(IDX_CNT) && !cnt_adv_i)
        |=> ($stable(cnt_q) && rsp_err_o));

    p_zero_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_write_i && req_addr_i == ADDR_W'(IDX_SIZE) &&
         req_wdata_i[SIZE_LSB +: SIZE_W] == '0) |=> ($stable(size_q) && rsp_err_o));

    p_soft_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq_o && size_q == SIZE_RST && cnt_q == '0 && !dma_en_o));

    p_chg_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_chg_o |-> (dma_en_o != $past(dma_en_o)));
endmodule

// File: tb/tb_audio_ctl_regbank.sv
`timescale 1ns/1ps
module tb_audio_ctl_regbank;
    import audio_rb_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic                rst_n;
    logic                req_valid_i, req_write_i;
    logic [ADDR_W-1:0]   req_addr_i;
    logic [WORD_W-1:0]   req_wdata_i;
    logic [WORD_W-1:0]   rsp_rdata_o;
    logic                rsp_err_o;
    logic [STAT_W-1:0]   fifo_stat_i;
    logic [NUM_LVL-1:0]  lvl_evt_i;
    logic                dma_evt_i, cnt_adv_i;
    logic [SIZE_W-1:0]   cnt_step_i;
    logic                dma_en_o, dma_en_chg_o, irq_o;

    audio_ctl_regbank dut (.*);

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";

    // Reference state.
    logic [31:0] m_ctl, m_dma, m_size;
    logic [23:0] m_cnt;
    logic [31:0] m_gen [17];
    logic [3:0]  m_fl;
    logic        m_df;
    logic [31:0] e_rd;
    logic        e_err, e_chg, e_irq;

    function automatic logic [31:0] m_read(int a);
        case (a)
            0:       return m_ctl | (32'(fifo_stat_i) << 7);
            8:       return m_dma | (32'(m_fl) << 20) | (32'(m_df) << 2);
            10:      return m_size;
            11:      return {8'h00, m_cnt};
            default: return m_gen[a];
        endcase
    endfunction

    task automatic m_clear();
        m_ctl = 0; m_dma = 0; m_size = 32'h7FFF_0000; m_cnt = 0;
        for (int i = 0; i < 17; i++) m_gen[i] = 0;
        m_fl = 0; m_df = 0;
    endtask

    task automatic model_step(bit v, bit w, int a, logic [31:0] d,
                              logic [3:0] hit, bit devt, bit adv, logic [15:0] st);
        bit         inwin = (a < 17);
        bit         srst = 0, dis = 0, dclr = 0, adv_ok;
        logic [3:0] set, clr = 0;
        bit         dset;
        logic [24:0] sum;
        e_err = 0; e_chg = 0;
        if (v && !w) e_rd = inwin ? m_read(a) : 32'h0;
        set  = hit & m_dma[27:24];
        dset = devt && m_dma[0];
        if (v && !inwin) e_err = 1;
        if (v && w && a == 11) e_err = 1;
        if (v && w && a == 10 && d[31:16] == 0) e_err = 1;
        adv_ok = adv && !(v && w && a == 10);
        if (adv_ok) begin
            sum = 25'(m_cnt) + 25'(st);
            m_cnt = (sum >= 25'(m_size[31:16])) ? 24'(sum - 25'(m_size[31:16])) : sum[23:0];
        end
        if (v && w && inwin) begin
            case (a)
                0: if (m_ctl[31] && !d[31]) srst = 1;
                   else m_ctl = (m_ctl & ~32'h8295_007F) | (d & 32'h8295_007F);
                8: begin
                    clr = d[19:16]; dclr = d[1];
                    dis = m_dma[0] && !d[0];
                    e_chg = (m_dma[0] != d[0]);
                    m_dma = (m_dma & ~32'hFF00_00FB) | (d & 32'hFF00_00FB);
                end
                10: if (d[31:16] != 0) begin
                    m_size = d;
                    if (24'(d[31:16]) <= m_cnt) m_cnt = 0;
                end
                11: ;
                default: m_gen[a] = d;
            endcase
        end
        if (srst) begin
            e_chg = m_dma[0];
            m_clear();
            m_ctl = d & 32'h8295_007F;
        end else if (dis) begin
            m_fl = 0; m_df = 0;
        end else begin
            m_fl = (m_fl & ~clr) | set;
            m_df = (m_df && !dclr) || dset;
        end
        e_irq = (|m_fl) || m_df;
    endtask

    task automatic chk(string sig, logic [31:0] got, logic [31:0] exp);
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s got %h exp %h at %0t", cur_req, sig, got, exp, $time);
        end
    endtask

    task automatic compare();
        vectors++;
        chk("rdata", rsp_rdata_o, e_rd);
        chk("err", 32'(rsp_err_o), 32'(e_err));
        chk("irq", 32'(irq_o), 32'(e_irq));
        chk("dma_en", 32'(dma_en_o), 32'(m_dma[0]));
        chk("dma_en_chg", 32'(dma_en_chg_o), 32'(e_chg));
    endtask

    task automatic cyc(bit v, bit w, int a, logic [31:0] d,
                       logic [3:0] hit = 0, bit devt = 0, bit adv = 0, logic [15:0] st = 0);
        req_valid_i = v; req_write_i = w; req_addr_i = ADDR_W'(a); req_wdata_i = d;
        lvl_evt_i = hit; dma_evt_i = devt; cnt_adv_i = adv; cnt_step_i = st;
        @(posedge clk);
        model_step(v, w, a, d, hit, devt, adv, st);
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int a, logic [31:0] d); cyc(1, 1, a, d); endtask
    task automatic rd(int a); cyc(1, 0, a, 0); cyc(0, 0, 0, 0); endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 0; req_valid_i = 0; req_write_i = 0; req_addr_i = 0; req_wdata_i = 0;
        fifo_stat_i = 9'h1A5; lvl_evt_i = 0; dma_evt_i = 0; cnt_adv_i = 0; cnt_step_i = 0;
        m_clear(); e_rd = 0; e_err = 0; e_chg = 0; e_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset image of every word, R12 read timing
        cur_req = "R1"; compare();
        for (int i = 0; i < 17; i++) rd(i);
        cur_req = "R12"; wr(3, 32'hCAFE_0003); rd(3); rd(5);
        // R2: masked control write and live status
        cur_req = "R2"; wr(0, 32'h7FFF_FFFF); rd(0);
        fifo_stat_i = 9'h05A; rd(0);
        wr(0, 32'h0000_0000); rd(0);
        // R4: masked DMA control write and readback composition
        cur_req = "R4"; wr(8, 32'hFFFF_FFFF); rd(8);
        wr(8, 32'h0F00_0021); rd(8);
        // R5: level and DMA events set flags, disabled level ignored
        cur_req = "R5"; cyc(0, 0, 0, 0, 4'b1011, 1); rd(8);
        wr(8, 32'h0000_0021); cyc(0, 0, 0, 0, 4'b1111, 0); rd(8);
        wr(8, 32'h0F00_0021);
        // R6: write-one-to-clear, and set beats clear in the same cycle
        cur_req = "R6"; cyc(0, 0, 0, 0, 4'b0110, 1); wr(8, 32'h0F05_0023); rd(8);
        cyc(1, 1, 8, 32'h0F0F_0023, 4'b0100, 0); rd(8);
        wr(8, 32'h0F0F_0023); rd(8);
        // R7: enable drop flushes flags, change pulses
        cur_req = "R7"; cyc(0, 0, 0, 0, 4'b0011, 1);
        cyc(1, 1, 8, 32'h0F00_0020, 4'b0001, 1); rd(8);
        wr(8, 32'h0F00_0020); wr(8, 32'h0F00_0021);
        // R9 / R10: size, count advance and reconcile
        cur_req = "R9"; wr(10, 32'h0000_1234); rd(10);
        wr(10, 32'h0005_0000); rd(10);
        cur_req = "R10"; cyc(0, 0, 0, 0, 0, 0, 1, 3); cyc(0, 0, 0, 0, 0, 0, 1, 3); rd(11);
        cyc(0, 0, 0, 0, 0, 0, 1, 5); rd(11);
        cyc(1, 1, 10, 32'h0009_0000, 0, 0, 1, 2); rd(11);
        cur_req = "R9"; wr(10, 32'h0001_0000); rd(11);
        // R8: count is read-only
        cur_req = "R8"; wr(10, 32'h0010_0000); cyc(0, 0, 0, 0, 0, 0, 1, 7);
        wr(11, 32'h0000_0003); rd(11);
        // R11: outside the window
        cur_req = "R11";
        for (int i = 17; i < 32; i++) begin cyc(1, 1, i, 32'hFFFF_FFFF); cyc(1, 0, i, 0); end
        rd(4); rd(10);
        // R3: software reset on falling bit 31
        cur_req = "R3"; wr(6, 32'h1111_6666); cyc(0, 0, 0, 0, 4'b1000, 1);
        wr(0, 32'h8000_0001); wr(0, 32'h8000_0002);
        cyc(1, 1, 0, 32'h0000_0005, 4'b1111, 1, 1, 1);
        for (int i = 0; i < 17; i++) rd(i);
        // Mixed random traffic
        cur_req = "R10";
        for (int n = 0; n < 3000; n++) begin
            int          a  = $urandom % 20;
            logic [31:0] d  = $urandom;
            bit          v  = ($urandom % 3) != 0;
            bit          w  = $urandom % 2;
            int          f  = int'(m_size[31:16]);
            if (a == 0 && ($urandom % 4) != 0) d[31] = 1'b0;
            if (a == 10 && ($urandom % 3) == 0) d[31:16] = 16'(1 + $urandom % 40);
            if (a == 8 && ($urandom % 2) == 0) d[0] = 1'b1;
            cyc(v, w, a, d, 4'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 1,
                16'($urandom % (f + 1)));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule